// File: doc/BRIEF.md
# Configuration Upgrade Status Tracker

This block keeps the control and status view of a two-image field upgrade scheme. A master state machine follows which of two configuration images is being loaded, whether that load is an ordinary one or a fallback after a running application image failed, and when the loaded image is running. While an application image runs, a user watchdog timer counts clock cycles. If the application does not kick the timer before the programmed limit, the machine falls back to the other image.

Every reconfiguration event writes a previous-state word. It holds one cause flag, chosen by a fixed priority, and a copy of the state code that was in force when the event fired. A current-state word always shows the live state code, the watchdog enable and the watchdog limit. Flash access, image loading and CRC calculation happen outside the block: load completion and error conditions arrive as single-cycle input pulses.

Top module: `cfg_upgrade_tracker`

## Requirements
- R1: The state code is 4 bits wide. 0010 means image 0 is loading, 0100 means image 1 is loading, 0011 means image 1 is loading as a fallback, 0101 means image 0 is loading as a fallback, 1000 means image 0 is running and 1001 means image 1 is running. After a synchronous reset the code is 0010.
- R2: `cur_state_o` carries the state code in bits 33:30, the watchdog enable (active high) in bit 29 and the 29-bit watchdog limit in bits 28:0. The enable and the limit are registered copies of their inputs, delayed by one clock. After reset bits 29:0 are zero.
- R3: In `prev_state_o` bits 27:26 and 21:0 always read zero. After reset the word holds 0010 in bits 25:22 and zero in every other bit.
- R4: The cause flags sit in `prev_state_o`: bit 31 for external reconfig, bit 30 for CRC error, bit 29 for status error and bit 28 for watchdog expiry. When several causes occur in the same cycle, only the highest-numbered one is set, and that cause also chooses the next state. A user reconfig request ranks below all four causes and sets no flag.
- R5: On every reconfiguration event the state code in force that cycle is copied into `prev_state_o` bits 25:22, at the same clock edge that writes the flags. In a cycle with no event, `prev_state_o` keeps its value.
- R6: A `load_done_i` pulse in a loading state moves the machine to the running state of the same image. In a running state the pulse has no effect.
- R7: An external or user reconfig that wins the priority moves the machine to the normal loading code of the image given by `img_sel_i` (0 gives 0010, 1 gives 0100), from any state.
- R8: A CRC error, a status error or a watchdog expiry that wins the priority moves the machine to the fallback loading code of the other image. From image 0 the target is 0011. From image 1 the target is 0101.
- R9: The watchdog counter starts at zero when a running state is entered and when `wd_kick_i` is high, and otherwise advances once per clock. Expiry fires in the cycle in which the count equals the registered limit. With limit T and no kick, the state changes at the (T+1)th edge after the edge that entered the running state.
- R10: The watchdog never expires while its registered enable is low or while the machine is in a loading state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_cfg_i | input | 1 | External reconfig pulse |
| crc_err_i | input | 1 | CRC error pulse |
| stat_err_i | input | 1 | Status error pulse |
| user_cfg_i | input | 1 | User reconfig request pulse |
| img_sel_i | input | 1 | Image chosen by an external or user reconfig |
| load_done_i | input | 1 | Image load complete pulse |
| wd_kick_i | input | 1 | Watchdog restart |
| wd_en_i | input | 1 | Watchdog enable |
| wd_tmo_i | input | 29 | Watchdog limit in clock cycles |
| cur_state_o | output | 34 | Current-state word |
| prev_state_o | output | 32 | Previous-state word |

## Verification
A wrong state register shows up at once in `cur_state_o` bits 33:30 at the next sample. It also shows up at the next reconfiguration, because the snapshot in `prev_state_o` bits 25:22 carries the wrong code. A wrong priority encoder sets the wrong or an extra flag, and it sends the machine to the wrong load code at the same edge. A watchdog counter that is off by one moves the fallback transition one cycle early or late, so the bench samples the state the cycle before the expected change and the cycle of it.

// File: rtl/cut_pkg.sv
package cut_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    ST_LOAD0    = 4'b0010,
    ST_LOAD1_FB = 4'b0011,
    ST_LOAD1    = 4'b0100,
    ST_LOAD0_FB = 4'b0101,
    ST_RUN0     = 4'b1000,
    ST_RUN1     = 4'b1001
  } msm_e;

  // cause flag order, highest index wins
  localparam int CZ_WD   = 0;
  localparam int CZ_STAT = 1;
  localparam int CZ_CRC  = 2;
  localparam int CZ_EXT  = 3;
  localparam int CZ_N    = 4;

  function automatic logic is_run(msm_e s);
    return (s == ST_RUN0) || (s == ST_RUN1);
  endfunction

  function automatic logic image_of(msm_e s);
    return (s == ST_LOAD1) || (s == ST_LOAD1_FB) || (s == ST_RUN1);
  endfunction

  function automatic msm_e normal_load(logic img);
    return img ? ST_LOAD1 : ST_LOAD0;
  endfunction

  // fallback targets the image other than the failing one
  function automatic msm_e fallback_load(logic failed_img);
    return failed_img ? ST_LOAD0_FB : ST_LOAD1_FB;
  endfunction

  function automatic msm_e run_of(logic img);
    return img ? ST_RUN1 : ST_RUN0;
  endfunction

endpackage

// File: rtl/cut_wdog.sv
module cut_wdog #(
  parameter int TMO_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             fire_o
);

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || kick_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = run_i && !kick_i && (cnt_q == tmo_i);

endmodule

// File: rtl/cut_cause_arb.sv
module cut_cause_arb
  import cut_pkg::*;
(
  input  logic            ext_i,
  input  logic            crc_i,
  input  logic            stat_i,
  input  logic            wd_i,
  input  logic            user_i,
  output logic            evt_o,
  output logic            fallback_o,
  output logic [CZ_N-1:0] flags_o
);

  logic [CZ_N-1:0] raw;

  always_comb begin
    raw          = '0;
    raw[CZ_EXT]  = ext_i;
    raw[CZ_CRC]  = crc_i;
    raw[CZ_STAT] = stat_i;
    raw[CZ_WD]   = wd_i;
  end

  // keep only the highest set cause
  always_comb begin
    flags_o = '0;
    for (int i = 0; i < CZ_N; i++) begin
      if (raw[i]) begin
        flags_o    = '0;
        flags_o[i] = 1'b1;
      end
    end
  end

  assign evt_o      = (|raw) || user_i;
  assign fallback_o = flags_o[CZ_CRC] || flags_o[CZ_STAT] || flags_o[CZ_WD];

endmodule

// File: rtl/cut_msm.sv
module cut_msm
  import cut_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic fallback_i,
  input  logic img_sel_i,
  input  logic load_done_i,
  output msm_e state_o
);

  msm_e state_q;
  msm_e state_d;

  always_comb begin
    state_d = state_q;
    if (evt_i) begin
      if (fallback_i) begin
        state_d = fallback_load(image_of(state_q));
      end else begin
        state_d = normal_load(img_sel_i);
      end
    end else if (load_done_i && !is_run(state_q)) begin
      state_d = run_of(image_of(state_q));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOAD0;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/cfg_upgrade_tracker.sv
module cfg_upgrade_tracker
  import cut_pkg::*;
#(
  parameter int TMO_W  = 29,
  parameter int PREV_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ext_cfg_i,
  input  logic                      crc_err_i,
  input  logic                      stat_err_i,
  input  logic                      user_cfg_i,
  input  logic                      img_sel_i,
  input  logic                      load_done_i,
  input  logic                      wd_kick_i,
  input  logic                      wd_en_i,
  input  logic [TMO_W-1:0]          wd_tmo_i,
  output logic [CODE_W+TMO_W:0]     cur_state_o,
  output logic [PREV_W-1:0]         prev_state_o
);

  localparam int FLAG_LO = PREV_W - CZ_N;
  localparam int SNAP_LO = FLAG_LO - 2 - CODE_W;

  msm_e            state;
  logic            en_q;
  logic [TMO_W-1:0] tmo_q;
  logic            wd_fire;
  logic            evt;
  logic            fallback;
  logic [CZ_N-1:0] flags;
  logic [PREV_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      tmo_q <= '0;
    end else begin
      en_q  <= wd_en_i;
      tmo_q <= wd_tmo_i;
    end
  end

  cut_wdog #(.TMO_W(TMO_W)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .run_i  (en_q && is_run(state)),
    .kick_i (wd_kick_i),
    .tmo_i  (tmo_q),
    .fire_o (wd_fire)
  );

  cut_cause_arb u_arb (
    .ext_i      (ext_cfg_i),
    .crc_i      (crc_err_i),
    .stat_i     (stat_err_i),
    .wd_i       (wd_fire),
    .user_i     (user_cfg_i),
    .evt_o      (evt),
    .fallback_o (fallback),
    .flags_o    (flags)
  );

  cut_msm u_msm (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt),
    .fallback_i  (fallback),
    .img_sel_i   (img_sel_i),
    .load_done_i (load_done_i),
    .state_o     (state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      prev_q[SNAP_LO +: CODE_W] <= ST_LOAD0;
    end else if (evt) begin
      prev_q <= '0;
      prev_q[FLAG_LO +: CZ_N]   <= flags;
      prev_q[SNAP_LO +: CODE_W] <= state;
    end
  end

  assign cur_state_o  = {state, en_q, tmo_q};
  assign prev_state_o = prev_q;

endmodule

// File: rtl/cfg_upgrade_tracker_chk.sv
module cfg_upgrade_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        ext_cfg_i,
  input logic        crc_err_i,
  input logic        stat_err_i,
  input logic        user_cfg_i,
  input logic        img_sel_i,
  input logic        load_done_i,
  input logic        wd_fire,
  input logic [33:0] cur_state_o,
  input logic [31:0] prev_state_o
);

  logic [3:0] code;
  logic       any_evt;
  logic       loading;
  assign code    = cur_state_o[33:30];
  assign any_evt = ext_cfg_i | crc_err_i | stat_err_i | user_cfg_i | wd_fire;
  assign loading = (code == 4'b0010) || (code == 4'b0011) ||
                   (code == 4'b0100) || (code == 4'b0101);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    loading || code == 4'b1000 || code == 4'b1001); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    prev_state_o[27:26] == 2'b00 && prev_state_o[21:0] == 22'd0); // R3

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prev_state_o[31:28])); // R4

  AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
    ext_cfg_i |=> prev_state_o[31] &&
      cur_state_o[33:30] == ($past(img_sel_i) ? 4'b0100 : 4'b0010)); // R7

  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> prev_state_o[25:22] == $past(code)); // R5

  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_evt |=> $stable(prev_state_o)); // R5

  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (rst)
    (loading && load_done_i && !any_evt) |=>
      cur_state_o[33:30] ==
        (($past(code) == 4'b0010 || $past(code) == 4'b0101) ? 4'b1000 : 4'b1001)); // R6

  AST_NO_WD_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
    loading |-> !wd_fire); // R10

endmodule

bind cfg_upgrade_tracker cfg_upgrade_tracker_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ext_cfg_i    (ext_cfg_i),
  .crc_err_i    (crc_err_i),
  .stat_err_i   (stat_err_i),
  .user_cfg_i   (user_cfg_i),
  .img_sel_i    (img_sel_i),
  .load_done_i  (load_done_i),
  .wd_fire      (wd_fire),
  .cur_state_o  (cur_state_o),
  .prev_state_o (prev_state_o)
);

// File: tb/cfg_upgrade_tracker_tb.sv
module cfg_upgrade_tracker_tb;

  localparam logic [3:0] C_L0 = 4'b0010, C_L1FB = 4'b0011, C_L1 = 4'b0100,
                         C_L0FB = 4'b0101, C_R0 = 4'b1000, C_R1 = 4'b1001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_cfg = 0, crc_err = 0, stat_err = 0, user_cfg = 0;
  logic        img_sel = 0, load_done = 0, wd_kick = 0, wd_en = 0;
  logic [28:0] wd_tmo = '0;
  logic [33:0] cur;
  logic [31:0] prev;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  cfg_upgrade_tracker u_dut (
    .clk(clk), .rst(rst), .ext_cfg_i(ext_cfg), .crc_err_i(crc_err),
    .stat_err_i(stat_err), .user_cfg_i(user_cfg), .img_sel_i(img_sel),
    .load_done_i(load_done), .wd_kick_i(wd_kick), .wd_en_i(wd_en),
    .wd_tmo_i(wd_tmo), .cur_state_o(cur), .prev_state_o(prev)
  );

  function automatic logic [31:0] pw(logic [3:0] flags, logic [3:0] code);
    return {flags, 2'b00, code, 22'd0};
  endfunction

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_clear();
    ext_cfg = 0; crc_err = 0; stat_err = 0; user_cfg = 0;
    load_done = 0; wd_kick = 0;
  endtask

  task automatic t_reset();
    check("R1 reset code", {30'd0, cur[33:30]}, {30'd0, C_L0});
    check("R2 reset fields", {4'd0, cur[29:0]}, 34'd0);
    check("R3 reset prev", {2'b0, prev}, {2'b0, pw(4'h0, C_L0)});
  endtask

  task automatic t_curword();
    wd_en = 1; wd_tmo = 29'h12345678;
    check("R2 delay", {4'd0, cur[29:0]}, 34'd0);
    step();
    check("R2 word", cur, {C_L0, 1'b1, 29'h12345678});
    wd_tmo = 29'd5; step();
    check("R2 limit", cur, {C_L0, 1'b1, 29'd5});
  endtask

  task automatic t_load_and_hold();
    logic [31:0] keep;
    keep = prev;
    step(20);
    check("R10 no expiry while loading", {30'd0, cur[33:30]}, {30'd0, C_L0});
    check("R5 prev hold", {2'b0, prev}, {2'b0, keep});
    load_done = 1; step(); pulse_clear();
    check("R6 load to run", {30'd0, cur[33:30]}, {30'd0, C_R0});
  endtask

  // image 0 running, limit 5; user request lands on the expiry cycle
  task automatic t_wd_expire_image0();
    step(4);
    check("R9 before expiry", {30'd0, cur[33:30]}, {30'd0, C_R0});
    load_done = 1; step(); pulse_clear();
    check("R6 done ignored in run", {30'd0, cur[33:30]}, {30'd0, C_R0});
    user_cfg = 1; img_sel = 1; step(); pulse_clear();
    check("R9 expiry at T+1", {30'd0, cur[33:30]}, {30'd0, C_L1FB});
    check("R4 wd beats user", {2'b0, prev}, {2'b0, pw(4'b0001, C_R0)});
  endtask

  task automatic t_wd_kick_image1();
    load_done = 1; step(); pulse_clear();
    check("R6 fallback load done", {30'd0, cur[33:30]}, {30'd0, C_R1});
    step(3);
    wd_kick = 1; step(); pulse_clear();
    step(5);
    check("R9 kick restarts", {30'd0, cur[33:30]}, {30'd0, C_R1});
    step();
    check("R8 wd from image1", {30'd0, cur[33:30]}, {30'd0, C_L0FB});
    check("R5 snapshot run1", {2'b0, prev}, {2'b0, pw(4'b0001, C_R1)});
  endtask

  task automatic t_wd_disabled();
    logic [31:0] keep;
    wd_en = 0;
    load_done = 1; step(); pulse_clear();
    check("R6 image0 fallback done", {30'd0, cur[33:30]}, {30'd0, C_R0});
    keep = prev;
    step(20);
    check("R10 disabled no expiry", {30'd0, cur[33:30]}, {30'd0, C_R0});
    check("R10 prev untouched", {2'b0, prev}, {2'b0, keep});
  endtask

  task automatic t_priority();
    ext_cfg = 1; crc_err = 1; stat_err = 1; user_cfg = 1; img_sel = 1;
    step(); pulse_clear();
    check("R4 ext highest", {2'b0, prev}, {2'b0, pw(4'b1000, C_R0)});
    check("R7 ext to load1", {30'd0, cur[33:30]}, {30'd0, C_L1});
    crc_err = 1; stat_err = 1; step(); pulse_clear();
    check("R4 crc over status", {2'b0, prev}, {2'b0, pw(4'b0100, C_L1)});
    check("R8 crc fallback", {30'd0, cur[33:30]}, {30'd0, C_L0FB});
    stat_err = 1; user_cfg = 1; img_sel = 1; step(); pulse_clear();
    check("R4 status over user", {2'b0, prev}, {2'b0, pw(4'b0010, C_L0FB)});
    check("R8 status fallback", {30'd0, cur[33:30]}, {30'd0, C_L1FB});
    user_cfg = 1; img_sel = 0; step(); pulse_clear();
    check("R7 user no flag", {2'b0, prev}, {2'b0, pw(4'b0000, C_L1FB)});
    check("R7 user to load0", {30'd0, cur[33:30]}, {30'd0, C_L0});
    ext_cfg = 1; load_done = 1; img_sel = 1; step(); pulse_clear();
    check("R6 event beats load done", {30'd0, cur[33:30]}, {30'd0, C_L1});
    check("R5 snapshot load0", {2'b0, prev}, {2'b0, pw(4'b1000, C_L0)});
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    step(3);
    rst = 0;
    step();
    t_reset();
    t_curword();
    t_load_and_hold();
    t_wd_expire_image0();
    t_wd_kick_image1();
    t_wd_disabled();
    t_priority();
    report();
  end

endmodule